// File: doc/BRIEF.md
# Timed Access Sequencer for Slow Asynchronous Memory

This controller sits between a clocked host and an asynchronous memory that has no clock of its own. The host raises a request for one cycle, with direction, address and write data. The sequencer then runs a fixed series of clock states, T1 to TN. For the whole series it holds the address, memory enable and the data-bus drive direction stable. When the series ends it signals completion.

The number of states N is fixed when the block is elaborated. It is the larger of the memory's read access time and its write-cycle time, divided by the clock period and rounded up. With a 20 ns clock, 65 ns access and 75 ns write cycle, N is 4.

For a write, an active-low strobe opens one state after the address becomes valid. It closes one state before the access ends. Address and data are therefore stable on both sides of the strobe. For a read, the memory output is sampled only at the close of the final state.

Top module: `slowmem_seq`

## Requirements
- R1: The access length N equals ceil(max(TACC_NS, TWC_NS) / CLK_NS). Elaboration rejects any setting that gives N below 3. With the defaults (20, 65, 75), N is 4.
- R2: While reset is held, and after it is released, the outputs are idle. `busy` = 0, `done` = 0, `mem_en` = 0, `mem_we_n` = 1, `mem_dout_en` = 0 and `rd_data` = 0.
- R3: A request is taken at a rising edge where `req` = 1 and `busy` = 0. `busy` is then 1 for exactly N cycles, numbered T1 to TN, and returns to 0 after TN.
- R4: From T1 to TN, `mem_addr` equals the accepted address and does not change. `mem_en` is 1 for exactly those cycles and 0 at all other times.
- R5: For a write, `mem_we_n` is 0 in states T2 through T(N-1) only. It is 1 in T1 and TN, for every read, and while idle.
- R6: For a write, `mem_dout_en` = 1 and `mem_wdata` equals the accepted data in every state T1 to TN. For a read, `mem_dout_en` stays 0.
- R7: After a read, `rd_data` holds the value on `mem_rdata` at the rising edge that ends TN. A write leaves `rd_data` unchanged.
- R8: `done` is 1 for the single cycle that follows TN and is 0 at all other times.
- R9: A request raised while `busy` = 1 is ignored. The address, direction and data of the running access are unchanged, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe from the host |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Access in progress (T1..TN) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| mem_addr | output | AW | Address to the memory |
| mem_en | output | 1 | Memory enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout_en | output | 1 | Drive write data onto the memory data bus |
| mem_wdata | output | DW | Write data to the memory |
| mem_rdata | input | DW | Read data from the memory |

## Verification
Take E0 as the edge that accepts a request. Each state Tk is then observed half a cycle after edge E(k-1). `done`, the idle control levels and the new `rd_data` are checked half a cycle after edge EN, and the end of the pulse one cycle later.

The bench's memory model returns inverted data until its own count of enabled cycles reaches the access time. A capture made earlier than TN therefore reads wrong data. The model commits a write only on the rising edge of the strobe, so a badly placed strobe shows up in a later read.

// File: rtl/slowmem_pkg.sv
package slowmem_pkg;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // States per access: slower of read access and write cycle, in clocks
   function automatic int access_cycles(input int clk_ns, input int tacc_ns, input int twc_ns);
      return ceil_div((tacc_ns > twc_ns) ? tacc_ns : twc_ns, clk_ns);
   endfunction

endpackage

// File: rtl/slowmem_timer.sv
module slowmem_timer #(
   parameter int NCYC = 4,
   parameter int PW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic [PW-1:0] phase,
   output logic          busy,
   output logic          last,
   output logic          done
);
   localparam logic [PW-1:0] LAST_PH = PW'(NCYC);

   initial begin
      AST_MIN_CYCLES : assert (NCYC >= 3) else $fatal(1, "access needs at least 3 states"); // R1
   end

   assign busy = (phase != '0);
   assign last = (phase == LAST_PH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
         done  <= 1'b0;
      end else begin
         done <= last;
         if (start)     phase <= PW'(1);
         else if (last) phase <= '0;
         else if (busy) phase <= phase + 1'b1;
      end
   end

   AST_DONE_ONE_CYCLE : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_BUSY_MIN_LEN : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy); // R3
   AST_PHASE_RANGE : assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST_PH); // R3

endmodule

// File: rtl/slowmem_strobe.sv
module slowmem_strobe #(
   parameter int NCYC = 4,
   parameter int PW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] phase,
   input  logic          op_we,
   output logic          mem_en,
   output logic          mem_we_n,
   output logic          mem_dout_en
);
   // Strobe window: states 2..NCYC-1, one state of margin on each side
   logic [NCYC:0] win;

   for (genvar k = 0; k <= NCYC; k++) begin : g_win
      if (k >= 2 && k <= NCYC - 1) begin : g_on
         assign win[k] = 1'b1;
      end else begin : g_off
         assign win[k] = 1'b0;
      end
   end

   assign mem_en      = (phase != '0);
   assign mem_dout_en = mem_en && op_we;
   assign mem_we_n    = !(op_we && win[phase]);

   AST_STROBE_IN_WINDOW : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_en && mem_dout_en)); // R5
   AST_STROBE_RELEASE : assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> mem_en); // R5

endmodule

// File: rtl/slowmem_dpath.sv
module slowmem_dpath #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          capture,
   input  logic [DW-1:0] mem_rdata,
   output logic          op_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] rd_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_we     <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (load) begin
         op_we     <= req_we;
         mem_addr  <= req_addr;
         mem_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_data <= '0;
      else if (capture) rd_data <= mem_rdata;
   end

   AST_ADDR_HELD : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(mem_addr) && $stable(op_we) && $stable(mem_wdata))); // R4
   AST_RDATA_ONLY_ON_CAPTURE : assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rd_data)); // R7

endmodule

// File: rtl/slowmem_seq.sv
module slowmem_seq #(
   parameter int CLK_NS  = 20,
   parameter int TACC_NS = 65,
   parameter int TWC_NS  = 75,
   parameter int AW      = 8,
   parameter int DW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_en,
   output logic          mem_we_n,
   output logic          mem_dout_en,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int NCYC = slowmem_pkg::access_cycles(CLK_NS, TACC_NS, TWC_NS);
   localparam int PW   = $clog2(NCYC + 1);

   logic [PW-1:0] phase;
   logic          last;
   logic          op_we;
   logic          accept;
   logic          capture;

   assign accept  = req && !busy;
   assign capture = last && !op_we;

   slowmem_timer #(.NCYC(NCYC), .PW(PW)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .phase(phase), .busy(busy), .last(last), .done(done)
   );

   slowmem_dpath #(.AW(AW), .DW(DW)) u_dpath (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .capture(capture), .mem_rdata(mem_rdata),
      .op_we(op_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_data(rd_data)
   );

   slowmem_strobe #(.NCYC(NCYC), .PW(PW)) u_strobe (
      .clk(clk), .rst_n(rst_n), .phase(phase), .op_we(op_we),
      .mem_en(mem_en), .mem_we_n(mem_we_n), .mem_dout_en(mem_dout_en)
   );

   AST_EN_MATCHES_BUSY : assert property (@(posedge clk) disable iff (!rst_n)
      mem_en == busy); // R4
   AST_DONE_AFTER_ACCESS : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(mem_en) && !mem_en)); // R8

endmodule

// File: tb/slowmem_seq_bench.sv
module slowmem_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int T_CLK = 20, T_ACC = 65, T_WC = 75;
   localparam int N   = ((T_ACC > T_WC ? T_ACC : T_WC) + T_CLK - 1) / T_CLK;
   localparam int RDV = (T_ACC + T_CLK - 1) / T_CLK;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req_we = 1'b0;
   logic [7:0] req_addr = '0, req_wdata = '0;
   logic busy, done, mem_en, mem_we_n, mem_dout_en;
   logic [7:0] rd_data, mem_addr, mem_wdata, mem_rdata;

   logic [7:0] model [256];
   logic [7:0] shadow [256];
   int en_cnt = 0;
   int nchk = 0, nfail = 0, cyc = 0;
   logic [7:0] exp_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slowmem_seq #(.CLK_NS(T_CLK), .TACC_NS(T_ACC), .TWC_NS(T_WC), .AW(8), .DW(8)) u_slowmem_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_en(mem_en), .mem_we_n(mem_we_n),
      .mem_dout_en(mem_dout_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // Memory model: output valid only once the access time has elapsed
   always @(posedge clk) en_cnt <= mem_en ? en_cnt + 1 : 0;
   assign mem_rdata = (en_cnt >= RDV - 1) ? model[mem_addr] : ~model[mem_addr];
   always @(posedge mem_we_n) if (mem_en && mem_dout_en) model[mem_addr] = mem_wdata;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nfail++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_we_n(input bit we, input int k);
      return !(we && k >= 2 && k <= N - 1);
   endfunction

   // Called at a negedge with busy low
   task automatic run_access(input bit we, input logic [7:0] a, input logic [7:0] d, input bit poke);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      chk("R3 idle before accept", busy, 1'b0);
      @(posedge clk);
      for (int k = 1; k <= N; k++) begin
         @(negedge clk);
         if (k == 1) req = 1'b0;
         chk("R3 busy in access", busy, 1'b1);
         chk("R4 mem_en in access", mem_en, 1'b1);
         chk("R4 address held", mem_addr, a);
         chk("R5 strobe placement", mem_we_n, exp_we_n(we, k));
         chk("R6 bus direction", mem_dout_en, we);
         if (we) chk("R6 write data held", mem_wdata, d);
         chk("R8 no done mid access", done, 1'b0);
         if (poke && k == 2) begin
            req = 1'b1; req_we = !we; req_addr = ~a; req_wdata = ~d;
         end
         if (poke && k == 3) req = 1'b0;
      end
      @(negedge clk);
      if (we) shadow[a] = d;
      else    exp_rd = shadow[a];
      chk("R8 done after TN", done, 1'b1);
      chk("R3 busy released", busy, 1'b0);
      chk("R4 mem_en released", mem_en, 1'b0);
      chk("R5 strobe idle", mem_we_n, 1'b1);
      chk("R6 bus released", mem_dout_en, 1'b0);
      chk("R7 read data", rd_data, exp_rd);
      @(negedge clk);
      chk("R8 done one cycle", done, 1'b0);
      chk("R9 no extra access", busy, 1'b0);
      chk("R9 no extra enable", mem_en, 1'b0);
   endtask

   initial begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < 256; i++) begin
         model[i]  = 8'(i * 7 + 3);
         shadow[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      chk("R2 busy in reset", busy, 1'b0);
      chk("R2 done in reset", done, 1'b0);
      chk("R2 mem_en in reset", mem_en, 1'b0);
      chk("R2 strobe in reset", mem_we_n, 1'b1);
      chk("R2 bus in reset", mem_dout_en, 1'b0);
      chk("R2 rd_data in reset", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 idle after reset", {busy, done, mem_en, mem_we_n, mem_dout_en}, 5'b00010);
      chk("R1 access length", N, 4);

      // Directed corners
      run_access(1'b0, 8'h00, 8'h00, 1'b0);   // R7 read low address
      run_access(1'b1, 8'hFF, 8'hA5, 1'b0);   // R5 write top address
      run_access(1'b0, 8'hFF, 8'h00, 1'b0);   // R7 read back written value
      run_access(1'b1, 8'h10, 8'hFF, 1'b1);   // R9 write with a request during busy
      run_access(1'b0, 8'h10, 8'h00, 1'b1);   // R9 read with a request during busy
      run_access(1'b1, 8'h20, 8'h3C, 1'b0);   // R7 write keeps rd_data
      // Random traffic
      for (int i = 0; i < 60; i++) begin
         logic [7:0] ra;
         ra = 8'($urandom_range(0, 15));
         run_access(1'($urandom), ra, 8'($urandom), 1'($urandom));
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule